// File: doc/BRIEF.md
# Two-Button Up/Down LED Counter

This block keeps an 8-bit count that drives a row of LEDs and is stepped by two push buttons: one raises the count by one, the other lowers it by one. All logic runs on one free-running system clock, nominally 50 MHz. The buttons are treated purely as data and never clock any flop.

Each raw button first crosses into the clock domain through a short flop chain. A debouncer then adopts a new level only once that input has held steady for a set number of clocks. A registered copy of each debounced level gives the level one cycle earlier. The four bits made from both buttons' earlier and present levels decide the step. The count moves only when exactly one button has just gone from released to pressed and the other button has been released in both cycles. Any other combination leaves the count alone.

Top module: `updown_led_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count, the debounced levels and the earlier-level copies are cleared to 0, so `count` reads 0 after reset.
- R2: A press of `btn_up` held longer than the debounce time, with `btn_dn` released, adds exactly one to `count`.
- R3: A press of `btn_dn` held longer than the debounce time, with `btn_up` released, subtracts exactly one from `count`.
- R4: The count wraps modulo 256: 255 plus one gives 0, and 0 minus one gives 255.
- R5: A button held down for any length of time produces exactly one step.
- R6: A level on a raw button that lasts fewer than `DEBOUNCE_CLKS` consecutive clocks is ignored and does not change `count`.
- R7: While one button is held down and debounced, a press of the other button does not change `count`.
- R8: When both debounced levels rise in the same clock, `count` does not change.
- R9: Releasing a button does not change `count`.
- R10: `count` changes by at most one, modulo 256, from one clock to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every flop updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_up | input | 1 | Raw, asynchronous button that raises the count; high means pressed |
| btn_dn | input | 1 | Raw, asynchronous button that lowers the count; high means pressed |
| count | output | CNT_W (8) | Registered count value that drives the LEDs |

## Verification
Two functions can land in the same clock: the increment decision and the decrement decision. This happens when both debounced levels rise together, or when one level rises while the other is already held. The bench provokes the first case by raising both raw inputs at the same clock edge. Both then pass the synchronizers and debouncers in lockstep, and `count` must stay where it was. For the second case, the bench holds one button and presses the other, and `count` must again stay unchanged through the press and through each release.

// File: rtl/updown_ctr_pkg.sv
package updown_ctr_pkg;

  localparam int BTN_UP = 0;
  localparam int BTN_DN = 1;
  localparam int N_BTN  = 2;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_t;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int HOLD_CLKS = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic level
);

  localparam int CW = (HOLD_CLKS > 1) ? $clog2(HOLD_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CLKS - 1);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b0;
      run_len <= '0;
    end else if (sync_in == level) begin
      run_len <= '0;
    end else if (run_len == LAST) begin
      level   <= sync_in;
      run_len <= '0;
    end else begin
      run_len <= run_len + CW'(1);
    end
  end

  // R6: the accepted level only ever moves to the value the input was showing
  a_r6_follow_input: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> (level == $past(sync_in)));

endmodule

// File: rtl/step_decide.sv
module step_decide
  import updown_ctr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  up_lvl,
  input  logic  dn_lvl,
  output step_t step
);

  logic up_prev, dn_prev;
  logic [3:0] pattern;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_prev <= 1'b0;
      dn_prev <= 1'b0;
    end else begin
      up_prev <= up_lvl;
      dn_prev <= dn_lvl;
    end
  end

  assign pattern = {dn_prev, dn_lvl, up_prev, up_lvl};

  always_comb begin
    case (pattern)
      4'b0001: step = STEP_INC;
      4'b0100: step = STEP_DEC;
      default: step = STEP_HOLD;
    endcase
  end

  // R5: a held level cannot request a second step on the next clock
  a_r5_single_inc: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_INC) |=> (step != STEP_INC));
  a_r5_single_dec: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_DEC) |=> (step != STEP_DEC));

endmodule

// File: rtl/updown_led_counter.sv
module updown_led_counter
  import updown_ctr_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int DEBOUNCE_CLKS = 500000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_up,
  input  logic             btn_dn,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [N_BTN-1:0] raw;
  logic [N_BTN-1:0] synced;
  logic [N_BTN-1:0] clean;
  step_t            step;

  assign raw[BTN_UP] = btn_up;
  assign raw[BTN_DN] = btn_dn;

  generate
    for (genvar b = 0; b < N_BTN; b++) begin : g_btn
      btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw[b]),
        .sync_out (synced[b])
      );
      btn_debounce #(.HOLD_CLKS(DEBOUNCE_CLKS)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .sync_in (synced[b]),
        .level   (clean[b])
      );
    end
  endgenerate

  step_decide u_step (
    .clk    (clk),
    .rst    (rst),
    .up_lvl (clean[BTN_UP]),
    .dn_lvl (clean[BTN_DN]),
    .step   (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case (step)
        STEP_INC: count <= count + ONE;
        STEP_DEC: count <= count - ONE;
        default:  count <= count;
      endcase
    end
  end

  // R2 and R4: an up decision lands one higher, wrapping past the top
  a_r2_inc: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_INC) |=> (count == $past(count) + ONE));
  // R3 and R4: a down decision lands one lower, wrapping below zero
  a_r3_dec: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_DEC) |=> (count == $past(count) - ONE));
  // R10: never more than one unit of movement per clock
  a_r10_unit_move: assert property (@(posedge clk) disable iff (rst)
    ##1 ((count == $past(count)) || (count == $past(count) + ONE) ||
         (count == $past(count) - ONE)));
  // R8: levels rising together never move the count
  a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
    ($rose(clean[BTN_UP]) && $rose(clean[BTN_DN])) |=> $stable(count));

endmodule

// File: tb/sim_updown_led_counter.sv
`timescale 1ns/1ps
module sim_updown_led_counter;

  localparam int W   = 8;
  localparam int DEB = 4;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up  = 1'b0;
  logic dn  = 1'b0;
  logic [W-1:0] count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  updown_led_counter #(.CNT_W(W), .SYNC_STAGES(2), .DEBOUNCE_CLKS(DEB)) u0 (
    .clk(clk), .rst(rst), .btn_up(up), .btn_dn(dn), .count(count)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input int expv);
    checks++;
    if (int'(count) != expv) begin
      errors++;
      $display("FAIL %s count=%0d expected=%0d", req, count, expv);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog count=%0d expected=finish", count);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    tick(5);
    check("R1", 0);
    rst = 1'b0;
    tick(SETTLE);
    check("R1", 0);

    // R2, R4, R5, R9: full sweep upward through the wrap
    for (int k = 0; k < 260; k++) begin
      up = 1'b1;
      tick(SETTLE);
      exp_cnt = (exp_cnt + 1) % 256;
      check("R2", exp_cnt);
      tick(SETTLE);
      check("R5", exp_cnt);
      up = 1'b0;
      tick(SETTLE);
      check("R9", exp_cnt);
    end
    check("R4", 4);

    // R3, R4: sweep downward through zero
    for (int k = 0; k < 260; k++) begin
      dn = 1'b1;
      tick(SETTLE);
      exp_cnt = (exp_cnt + 255) % 256;
      check("R3", exp_cnt);
      dn = 1'b0;
      tick(SETTLE);
      check("R9", exp_cnt);
    end
    check("R4", 0);

    // R6: pulses shorter than the debounce window, every width below it
    for (int w = 1; w < DEB; w++) begin
      for (int rep = 0; rep < 3; rep++) begin
        up = 1'b1; tick(w); up = 1'b0; tick(w);
        dn = 1'b1; tick(w); dn = 1'b0; tick(w);
      end
      tick(SETTLE);
      check("R6", exp_cnt);
    end

    // R8: both buttons pressed on the same clock
    for (int rep = 0; rep < 4; rep++) begin
      up = 1'b1; dn = 1'b1;
      tick(SETTLE);
      check("R8", exp_cnt);
      up = 1'b0; dn = 1'b0;
      tick(SETTLE);
      check("R8", exp_cnt);
    end

    // R7: hold up, then press down; hold down, then press up
    up = 1'b1; tick(SETTLE);
    exp_cnt = (exp_cnt + 1) % 256;
    check("R2", exp_cnt);
    dn = 1'b1; tick(SETTLE);
    check("R7", exp_cnt);
    up = 1'b0; tick(SETTLE);
    check("R7", exp_cnt);
    up = 1'b1; tick(SETTLE);
    check("R7", exp_cnt);
    dn = 1'b0; tick(SETTLE);
    check("R7", exp_cnt);
    up = 1'b0; tick(SETTLE);
    check("R9", exp_cnt);

    // R1: reset in mid-count
    up = 1'b1; tick(SETTLE);
    exp_cnt = (exp_cnt + 1) % 256;
    check("R2", exp_cnt);
    rst = 1'b1; tick(3);
    check("R1", 0);
    rst = 1'b0; tick(SETTLE);
    check("R1", 1);   // held button re-accepted from cleared level: one step
    up = 1'b0; tick(SETTLE);
    check("R9", 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule